// File: doc/BRIEF.md
# Two-Level Random Early Drop Admission Check

This block sits at the entry of one egress priority queue and rules on each arriving frame: admit it or discard it. It looks at how full the queue is, in granules, and compares that against two programmable thresholds. Below the lower threshold every frame gets in. Between the thresholds a frame is discarded at random, with a probability that depends on whether it carries the high-drop or the low-drop mark. Above the upper threshold, high-drop frames are always discarded and low-drop frames are discarded at random with a third probability.

Arrivals form a stream with a valid strobe only. The block is always ready, so it never applies back-pressure, and a strobe may be asserted on every cycle. Each strobe produces exactly one verdict pulse one clock later. The thresholds and percentages are plain static inputs that a register file outside this block drives. A 16-bit linear feedback shift register inside the block supplies the random numbers.

Top module: `wred_admit`

## Requirements
- R1: A threshold input value N stands for 16×N granules. A zone is entered only when the occupancy is strictly greater than 16×N.
- R2: When the occupancy is at or below the lower threshold, and not above the upper one, every frame is admitted (verdict_drop = 0), whatever its mark.
- R3: Between the thresholds, a high-drop frame is discarded exactly when the scaled random value is below pct_mid_hd.
- R4: Between the thresholds, a low-drop frame is discarded exactly when the scaled random value is below pct_mid_ld.
- R5: Above the upper threshold, a high-drop frame is always discarded.
- R6: Above the upper threshold, a low-drop frame is discarded exactly when the scaled random value is below pct_top_ld.
- R7: When the occupancy is above the upper threshold, the upper-zone rules apply even if the upper threshold is programmed below the lower one.
- R8: A percentage above 100 acts as 100, so the frame is always discarded. A percentage of 0 never discards.
- R9: The random source is a Galois shift register that resets to 16'hACE1. Its next value is s>>1, XORed with 16'hB400 when bit 0 of s is 1. The scaled value is (s×100)>>16, which lies in the range 0 to 99. Each arrival uses the current s, and s advances exactly once per arrival and never on idle cycles.
- R10: verdict_valid pulses for one cycle, exactly one clock after each cycle in which arr_valid is high, and is low at all other times, including in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_level | input | OCC_W | Current queue occupancy in granules |
| arr_valid | input | 1 | Frame arrival strobe (always accepted) |
| arr_high_drop | input | 1 | 1 = high-drop mark, 0 = low-drop mark |
| thr_lo | input | THR_W | Lower threshold, units of 16 granules |
| thr_hi | input | THR_W | Upper threshold, units of 16 granules |
| pct_mid_hd | input | PCT_W | Discard percentage for high-drop frames between the thresholds |
| pct_mid_ld | input | PCT_W | Discard percentage for low-drop frames between the thresholds |
| pct_top_ld | input | PCT_W | Discard percentage for low-drop frames above the upper threshold |
| verdict_valid | output | 1 | One-cycle pulse carrying a verdict |
| verdict_drop | output | 1 | 1 = discard, 0 = admit; meaningful while verdict_valid is high |

## Verification
The shift register state cannot be seen directly, so any error in it shows up only as a wrong admit or discard verdict. Such an error can lie hidden for several arrivals and surface at the first frame whose scaled value falls near the active percentage. The bench therefore keeps its own copy of the register and checks long runs of arrivals in each zone, with idle gaps between them. An extra or missing advance, or a wrong seed, then breaks the agreement within a few verdicts. A wrong zone boundary or a wrong percentage choice shows at the very next verdict, because the bench places occupancies on both sides of each 16×N edge.

// File: rtl/wred_pkg.sv
package wred_pkg;
  typedef enum logic [1:0] {
    ZONE_CLEAR = 2'd0,
    ZONE_MID   = 2'd1,
    ZONE_HIGH  = 2'd2
  } zone_e;
endpackage

// File: rtl/wred_lfsr.sv
module wred_lfsr #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     TAPS = 16'hB400,
  parameter logic [W-1:0]     SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = state >> 1;
    if (state[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= nxt;
  end

  // R9: a maximal-length register never reaches the all-zero lock state
  assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R9: the state holds still on cycles with no arrival
  assert_lfsr_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
endmodule

// File: rtl/wred_zone_cmp.sv
module wred_zone_cmp
  import wred_pkg::*;
#(
  parameter int OCC_W      = 16,
  parameter int THR_W      = 8,
  parameter int GRAN_SHIFT = 4
) (
  input  logic [OCC_W-1:0] occ,
  input  logic [THR_W-1:0] thr_lo,
  input  logic [THR_W-1:0] thr_hi,
  output zone_e            zone
);
  localparam int TG_W = THR_W + GRAN_SHIFT;
  localparam int CW   = (OCC_W > TG_W) ? OCC_W : TG_W;

  logic [CW-1:0] occ_x, lo_g, hi_g;

  assign occ_x = CW'(occ);
  assign lo_g  = CW'({thr_lo, {GRAN_SHIFT{1'b0}}});
  assign hi_g  = CW'({thr_hi, {GRAN_SHIFT{1'b0}}});

  // Upper rule is tested first, so it wins even when thr_hi < thr_lo
  always_comb begin
    if (occ_x > hi_g)      zone = ZONE_HIGH;
    else if (occ_x > lo_g) zone = ZONE_MID;
    else                   zone = ZONE_CLEAR;
  end
endmodule

// File: rtl/wred_pct_sel.sv
module wred_pct_sel
  import wred_pkg::*;
#(
  parameter int PCT_W = 7,
  parameter int PCT_MAX = 100
) (
  input  zone_e            zone,
  input  logic             high_drop,
  input  logic [PCT_W-1:0] pct_mid_hd,
  input  logic [PCT_W-1:0] pct_mid_ld,
  input  logic [PCT_W-1:0] pct_top_ld,
  output logic             force_drop,
  output logic [PCT_W-1:0] pct_eff
);
  logic [PCT_W-1:0] raw;

  always_comb begin
    force_drop = 1'b0;
    raw        = '0;
    unique case (zone)
      ZONE_MID:  raw = high_drop ? pct_mid_hd : pct_mid_ld;
      ZONE_HIGH: begin
        if (high_drop) force_drop = 1'b1;
        else           raw        = pct_top_ld;
      end
      default:   raw = '0;
    endcase
  end

  assign pct_eff = (raw > PCT_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : raw;
endmodule

// File: rtl/wred_admit.sv
module wred_admit
  import wred_pkg::*;
#(
  parameter int OCC_W      = 16,
  parameter int THR_W      = 8,
  parameter int PCT_W      = 7,
  parameter int GRAN_SHIFT = 4,
  parameter int RND_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ_level,
  input  logic             arr_valid,
  input  logic             arr_high_drop,
  input  logic [THR_W-1:0] thr_lo,
  input  logic [THR_W-1:0] thr_hi,
  input  logic [PCT_W-1:0] pct_mid_hd,
  input  logic [PCT_W-1:0] pct_mid_ld,
  input  logic [PCT_W-1:0] pct_top_ld,
  output logic             verdict_valid,
  output logic             verdict_drop
);
  localparam int PROD_W = RND_W + PCT_W;

  zone_e             zone;
  logic              force_drop;
  logic [PCT_W-1:0]  pct_eff;
  logic [RND_W-1:0]  rnd;
  logic [PROD_W-1:0] prod;
  logic [PCT_W-1:0]  scaled;
  logic              drop_d;

  wred_lfsr #(.W(RND_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(arr_valid), .state(rnd)
  );

  wred_zone_cmp #(.OCC_W(OCC_W), .THR_W(THR_W), .GRAN_SHIFT(GRAN_SHIFT)) u_zone (
    .occ(occ_level), .thr_lo(thr_lo), .thr_hi(thr_hi), .zone(zone)
  );

  wred_pct_sel #(.PCT_W(PCT_W)) u_sel (
    .zone(zone), .high_drop(arr_high_drop),
    .pct_mid_hd(pct_mid_hd), .pct_mid_ld(pct_mid_ld), .pct_top_ld(pct_top_ld),
    .force_drop(force_drop), .pct_eff(pct_eff)
  );

  // Map the random word onto 0..99 by multiply and take the top bits
  assign prod   = PROD_W'(rnd) * PROD_W'(100);
  assign scaled = PCT_W'(prod >> RND_W);
  assign drop_d = force_drop || (scaled < pct_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      verdict_drop  <= 1'b0;
    end else begin
      verdict_valid <= arr_valid;
      verdict_drop  <= arr_valid & drop_d;
    end
  end

  // R10: one verdict pulse per arrival, one clock later
  assert_verdict_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |=> verdict_valid);
  assert_verdict_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_valid |=> !verdict_valid);
  // R2: the clear zone never discards
  assert_clear_admits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && zone == ZONE_CLEAR) |=> !verdict_drop);
  // R5: high-drop frames above the upper threshold always go
  assert_top_hd_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && zone == ZONE_HIGH && arr_high_drop) |=> verdict_drop);
  // R8: saturated percentage always discards, zero never does
  assert_pct_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && pct_eff == PCT_W'(100)) |=> verdict_drop);
  assert_pct_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !force_drop && pct_eff == '0) |=> !verdict_drop);
endmodule

// File: tb/tb_wred_admit.sv
`timescale 1ns/1ps
module tb_wred_admit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] occ_level = '0;
  logic       arr_valid = 1'b0;
  logic       arr_high_drop = 1'b0;
  logic [7:0] thr_lo = 8'd4, thr_hi = 8'd8;
  logic [6:0] pct_mid_hd = 7'd50, pct_mid_ld = 7'd20, pct_top_ld = 7'd70;
  logic       verdict_valid, verdict_drop;

  int checks = 0;
  int errors = 0;
  logic [15:0] model_s = 16'hACE1;
  bit  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  wred_admit dut (
    .clk(clk), .rst_n(rst_n), .occ_level(occ_level), .arr_valid(arr_valid),
    .arr_high_drop(arr_high_drop), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .pct_mid_hd(pct_mid_hd), .pct_mid_ld(pct_mid_ld), .pct_top_ld(pct_top_ld),
    .verdict_valid(verdict_valid), .verdict_drop(verdict_drop)
  );

  function automatic int sat(input int p);
    return (p > 100) ? 100 : p;
  endfunction

  // Driver: presents one arrival and pushes the expected verdict (R1..R9 model)
  task automatic send(input int occ, input bit hd, input string tag);
    int scaled, lo, hi;
    bit exp;
    @(negedge clk);
    occ_level = 16'(occ); arr_high_drop = hd; arr_valid = 1'b1;
    scaled = (int'(model_s) * 100) >>> 16;
    lo = 16 * int'(thr_lo); hi = 16 * int'(thr_hi);
    if (occ > hi)      exp = hd ? 1'b1 : (scaled < sat(int'(pct_top_ld)));
    else if (occ > lo) exp = (scaled < sat(hd ? int'(pct_mid_hd) : int'(pct_mid_ld)));
    else               exp = 1'b0;
    model_s = model_s[0] ? ((model_s >> 1) ^ 16'hB400) : (model_s >> 1);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    arr_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares as verdicts appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (verdict_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10: verdict without arrival, actual valid=1 expected valid=0");
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (verdict_drop !== e) begin
            errors++;
            $display("FAIL %s: drop actual=%0b expected=%0b", t, verdict_drop, e);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (verdict_valid !== 1'b0 || verdict_drop !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset outputs actual=%0b%0b expected=00", verdict_valid, verdict_drop);
    end
    rst_n = 1'b1;
    idle(2);

    // R1/R2 boundaries: 64 is not above 16*4, 65 is; 128 vs 129 for the top
    send(64, 1'b1, "R2");
    send(64, 1'b0, "R2");
    send(0,  1'b1, "R2");
    for (int i = 0; i < 6; i++) send(65, 1'b1, "R1");
    for (int i = 0; i < 6; i++) send(128, 1'b0, "R1");
    send(129, 1'b1, "R1");
    idle(3);
    // R3 / R4: mid zone, both marks, with gaps to catch idle advances (R9)
    for (int i = 0; i < 24; i++) send(100, 1'b1, "R3");
    idle(5);
    for (int i = 0; i < 24; i++) begin send(90, 1'b0, "R4"); if (i % 5 == 0) idle(2); end
    // R5 / R6: top zone
    for (int i = 0; i < 12; i++) send(300, 1'b1, "R5");
    for (int i = 0; i < 24; i++) send(200, 1'b0, "R6");
    idle(4);
    // R9: long run checks the sequence itself
    pct_mid_hd = 7'd37;
    for (int i = 0; i < 60; i++) begin send(70 + (i % 50), i[0], "R9"); if (i % 7 == 3) idle(1); end
    // R8: saturation and zero
    idle(1);
    pct_mid_hd = 7'd127; pct_mid_ld = 7'd0; pct_top_ld = 7'd101;
    for (int i = 0; i < 10; i++) send(100, 1'b1, "R8");
    for (int i = 0; i < 10; i++) send(100, 1'b0, "R8");
    for (int i = 0; i < 10; i++) send(500, 1'b0, "R8");
    idle(2);
    // R7: upper threshold below lower one
    thr_lo = 8'd10; thr_hi = 8'd3;
    pct_mid_hd = 7'd50; pct_mid_ld = 7'd50; pct_top_ld = 7'd0;
    for (int i = 0; i < 8; i++) send(100, 1'b1, "R7");
    for (int i = 0; i < 8; i++) send(100, 1'b0, "R7");
    send(48, 1'b1, "R7");
    send(49, 1'b1, "R7");
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: missing verdicts actual=%0d pending expected=0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule